// File: doc/BRIEF.md
# Chained Two-Channel Timestamp Counter

This block builds a free-running time base out of two narrow up-counters. The low channel counts ticks of a divided system clock. The divide ratio comes from a small select input. From its own count, the low channel makes a square wave. The wave is set when the count reaches zero and cleared when the count reaches half of its range. The high channel does not watch a carry. It counts rising edges of that wave, so it advances once for each full turn of the low channel.

Each channel has its own start and stop command. A single sync command clears both counts and the prescaler phase together, so software can start a timestamp epoch from a known point. The high half moves one clock after the low half wraps. Software therefore builds a coherent wide value as (high << CW) | low: it reads high, then low, then high again, and retries when the two high reads differ. A one-bit read select gives either half on one read port.

A second mode turns the low channel into one native counter of twice the width. In that mode the high channel stays idle.

Top module: `cascade_timebase`

## Requirements
- R1: After reset, both counts, the wave output and the read port are zero, and both channels are stopped, so no count moves until a start command.
- R2: With select value s, a running low channel advances by one every 2^(2s+1) clock cycles. After a sync, it holds floor(n / 2^(2s+1)) n cycles later.
- R3: In chained mode, the low count wraps from 2^CW-1 to 0.
- R4: The wave output goes to 1 in the cycle the low count becomes 0, and goes to 0 in the cycle the low count becomes 2^(CW-1). A sync clears it to 0.
- R5: A running high channel increments by exactly one, one clock cycle after each rising edge of the wave. A stopped high channel ignores those edges.
- R6: A stop command freezes the low count without clearing it. A later start command resumes counting from the frozen value at the following prescaled ticks.
- R7: A sync command clears both counts, the wave and the prescaler phase in one cycle, and leaves the run state of each channel unchanged.
- R8: When start and stop for a channel arrive in the same cycle, stop wins.
- R9: With wide mode set, the low channel is one 2*CW-bit counter whose full value appears on the read port. The high count does not change and the wave stays 0.
- R10: The read port shows the high count (zero-extended) when the read select is 1. When it is 0, it shows the low count (zero-extended in chained mode), in the same cycle.
- R11: A sync arriving in the same cycle as a prescaled tick still leaves the low count at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| presc_sel | input | SELW | Prescaler select, divide by 2^(2s+1) |
| wide_mode | input | 1 | 1: single double-width counter; 0: chained channels |
| lo_start | input | 1 | Start command for the low channel |
| lo_stop | input | 1 | Stop command for the low channel |
| hi_start | input | 1 | Start command for the high channel |
| hi_stop | input | 1 | Stop command for the high channel |
| sync_all | input | 1 | Clear both counters and the prescaler phase |
| rd_sel | input | 1 | Read select: 0 low, 1 high |
| lo_count | output | CW | Low channel count |
| hi_count | output | CW | High channel count |
| lo_wave | output | 1 | Square wave made by the low channel's compare matches |
| rd_data | output | 2*CW | Register-style read result |

## Verification
The bench builds the block with CW = 8 and the default two-bit prescaler select. With divide-by-two, the low channel wraps every 512 cycles. This lets the bench observe, within a few thousand cycles, the exact wrap cycle, the wave's rise and fall, the one-cycle lag of the high half and two successive high increments. The divide-by-eight setting checks the prescaler ratio. Wide mode at this width lets the low channel run past 255, which shows that no wrap happens at CW bits in that mode.

// File: rtl/cascade_timebase.sv
module cascade_timebase #(
  parameter int CW   = 16,
  parameter int SELW = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [SELW-1:0] presc_sel,
  input  logic            wide_mode,
  input  logic            lo_start,
  input  logic            lo_stop,
  input  logic            hi_start,
  input  logic            hi_stop,
  input  logic            sync_all,
  input  logic            rd_sel,
  output logic [CW-1:0]   lo_count,
  output logic [CW-1:0]   hi_count,
  output logic            lo_wave,
  output logic [2*CW-1:0] rd_data
);

  localparam int WW  = 2 * CW;
  localparam int PCW = 2 * (2 ** SELW) - 1;
  localparam logic [CW-1:0] CMP_SET = '0;
  localparam logic [CW-1:0] CMP_CLR = {1'b1, {(CW-1){1'b0}}};

  logic [PCW-1:0] pc;
  logic [PCW-1:0] pmask;
  logic           lo_run, hi_run;
  logic           tick;
  logic [WW-1:0]  cnt;
  logic [CW-1:0]  lo_nxt;
  logic           wave_d;
  logic           hi_inc;

  assign pmask  = PCW'((32'd1 << (2 * int'(presc_sel) + 1)) - 32'd1);
  assign tick   = lo_run && ((pc & pmask) == pmask);
  assign lo_nxt = cnt[CW-1:0] + 1'b1;
  assign hi_inc = hi_run && !wide_mode && lo_wave && !wave_d;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)        pc <= '0;
    else if (sync_all) pc <= '0;
    else               pc <= pc + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      lo_run <= 1'b0;
      hi_run <= 1'b0;
    end else begin
      if (lo_stop)       lo_run <= 1'b0;
      else if (lo_start) lo_run <= 1'b1;
      if (hi_stop)       hi_run <= 1'b0;
      else if (hi_start) hi_run <= 1'b1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)        cnt <= '0;
    else if (sync_all) cnt <= '0;
    else if (tick)     cnt <= wide_mode ? cnt + 1'b1 : {{CW{1'b0}}, lo_nxt};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      lo_wave <= 1'b0;
      wave_d  <= 1'b0;
    end else if (sync_all) begin
      lo_wave <= 1'b0;
      wave_d  <= 1'b0;
    end else begin
      wave_d <= lo_wave;
      if (wide_mode)                          lo_wave <= 1'b0;
      else if (tick && lo_nxt == CMP_SET)     lo_wave <= 1'b1;
      else if (tick && lo_nxt == CMP_CLR)     lo_wave <= 1'b0;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)        hi_count <= '0;
    else if (sync_all) hi_count <= '0;
    else if (hi_inc)   hi_count <= hi_count + 1'b1;

  assign lo_count = cnt[CW-1:0];
  assign rd_data  = rd_sel    ? {{CW{1'b0}}, hi_count} :
                    wide_mode ? cnt : {{CW{1'b0}}, cnt[CW-1:0]};

  p_lo_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !sync_all |=> (lo_count == $past(lo_count) || lo_count == CW'($past(lo_count) + 1'b1)));

  p_hold_stopped_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!lo_run && !sync_all) |=> $stable(cnt));

  p_wave_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lo_wave) |-> lo_count == CMP_SET);

  p_wave_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(lo_wave) && !$past(sync_all) && !$past(wide_mode)) |-> lo_count == CMP_CLR);

  p_hi_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !sync_all |=> (hi_count == $past(hi_count) || hi_count == CW'($past(hi_count) + 1'b1)));

  p_sync_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    sync_all |=> (lo_count == '0 && hi_count == '0 && !lo_wave));

  p_hi_idle_wide_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wide_mode && !sync_all) |=> $stable(hi_count));

endmodule

// File: tb/cascade_timebase_test.sv
`timescale 1ns/1ps
module cascade_timebase_test;
  localparam int CW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [1:0]    presc_sel = '0;
  logic          wide_mode = 1'b0;
  logic          lo_start = 1'b0, lo_stop = 1'b0, hi_start = 1'b0, hi_stop = 1'b0;
  logic          sync_all = 1'b0, rd_sel = 1'b0;
  logic [CW-1:0] lo_count, hi_count;
  logic          lo_wave;
  logic [2*CW-1:0] rd_data;

  int checks = 0, errors = 0, since = 0;

  cascade_timebase #(.CW(CW), .SELW(2)) uut (
    .clk(clk), .rst_n(rst_n), .presc_sel(presc_sel), .wide_mode(wide_mode),
    .lo_start(lo_start), .lo_stop(lo_stop), .hi_start(hi_start), .hi_stop(hi_stop),
    .sync_all(sync_all), .rd_sel(rd_sel), .lo_count(lo_count), .hi_count(hi_count),
    .lo_wave(lo_wave), .rd_data(rd_data));

  always #4 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic advance_to(input int n);
    while (since < n) begin
      @(posedge clk);
      since++;
    end
    #2;
  endtask

  task automatic do_sync;
    sync_all = 1'b1;
    @(posedge clk);
    #2 sync_all = 1'b0;
    since = 0;
  endtask

  task automatic pulse(input bit lo_s, input bit lo_p, input bit hi_s, input bit hi_p);
    lo_start = lo_s; lo_stop = lo_p; hi_start = hi_s; hi_stop = hi_p;
    @(posedge clk);
    since++;
    #2 {lo_start, lo_stop, hi_start, hi_stop} = '0;
  endtask

  task automatic t_reset;
    chk("R1 lo", 32'(lo_count), 0);
    chk("R1 hi", 32'(hi_count), 0);
    chk("R1 wave", 32'(lo_wave), 0);
    chk("R1 rd", 32'(rd_data), 0);
    since = 0;
    advance_to(20);
    chk("R1 stopped lo", 32'(lo_count), 0);
  endtask

  task automatic t_prescale;
    pulse(1, 0, 1, 0);
    presc_sel = 2'd1;
    do_sync();
    advance_to(80);
    chk("R2 div8 at 80", 32'(lo_count), 10);
    advance_to(87);
    chk("R2 div8 at 87", 32'(lo_count), 10);
    presc_sel = 2'd0;
    do_sync();
    advance_to(50);
    chk("R2 div2 at 50", 32'(lo_count), 25);
  endtask

  task automatic t_wrap_wave;
    do_sync();
    advance_to(256);
    chk("R4 no wave before wrap", 32'(lo_wave), 0);
    advance_to(511);
    chk("R3 top value", 32'(lo_count), 255);
    chk("R4 low before wrap", 32'(lo_wave), 0);
    advance_to(512);
    chk("R3 wrap to zero", 32'(lo_count), 0);
    chk("R4 rise at zero", 32'(lo_wave), 1);
    chk("R5 hi lags", 32'(hi_count), 0);
    advance_to(513);
    chk("R5 hi after rise", 32'(hi_count), 1);
    advance_to(767);
    chk("R4 high below half", 32'(lo_wave), 1);
    advance_to(768);
    chk("R4 fall at half", 32'(lo_wave), 0);
    rd_sel = 1'b1; #1;
    chk("R10 read high", 32'(rd_data), 1);
    rd_sel = 1'b0; #1;
    chk("R10 read low", 32'(rd_data), 128);
    advance_to(1025);
    chk("R5 second increment", 32'(hi_count), 2);
  endtask

  task automatic t_hi_stopped;
    pulse(0, 0, 0, 1);
    do_sync();
    advance_to(600);
    chk("R5 stopped hi", 32'(hi_count), 0);
    chk("R3 lo wrapped", 32'(lo_count), 44);
    chk("R4 wave after wrap", 32'(lo_wave), 1);
  endtask

  task automatic t_freeze;
    do_sync();
    advance_to(100);
    chk("R6 before stop", 32'(lo_count), 50);
    pulse(0, 1, 0, 0);
    advance_to(141);
    chk("R6 frozen", 32'(lo_count), 50);
    pulse(1, 0, 0, 0);
    advance_to(162);
    chk("R6 resumed", 32'(lo_count), 60);
    pulse(1, 1, 0, 0);
    advance_to(200);
    chk("R8 stop wins", 32'(lo_count), 60);
  endtask

  task automatic t_sync_mid;
    pulse(1, 0, 1, 0);
    do_sync();
    advance_to(33);
    do_sync();
    chk("R11 sync on tick lo", 32'(lo_count), 0);
    chk("R7 sync hi", 32'(hi_count), 0);
    chk("R7 sync wave", 32'(lo_wave), 0);
    advance_to(10);
    chk("R7 run kept", 32'(lo_count), 5);
  endtask

  task automatic t_wide;
    wide_mode = 1'b1;
    do_sync();
    advance_to(600);
    chk("R9 wide read", 32'(rd_data), 300);
    chk("R9 low port", 32'(lo_count), 44);
    chk("R9 hi idle", 32'(hi_count), 0);
    chk("R9 wave idle", 32'(lo_wave), 0);
    advance_to(1100);
    chk("R9 wide read 2", 32'(rd_data), 550);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    t_reset();
    t_prescale();
    t_wrap_wave();
    t_hi_stopped();
    t_freeze();
    t_sync_mid();
    t_wide();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 8);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule